// File: doc/BRIEF.md
# Pipelined Streaming Read Master

This block fetches a run of consecutive 32-bit words from a single-layer AHB-Lite style bus. A one-cycle command pulse supplies a byte start address and a word count. The master then places one address phase on the bus per cycle and increments the address by four each time. Every new address phase coincides with the data phase of the word before it. A zero-wait slave therefore returns one word per cycle after a single fill cycle.

Each accepted word comes out on a registered valid/data pair. A one-cycle completion pulse arrives together with the final word. When the slave stretches a data phase, the whole pipeline holds. The address, the transfer type and the remaining count stay where they are until the slave accepts.

Two counters are restarted with each run. One counts the bus cycles the run occupies and the other counts the words accepted. Their difference is the fill cycle plus all stall cycles, so a bench can measure the throughput the slave actually delivered.

Top module: `ahbl_stream_reader`

## Requirements
- R1: In a run of more than one word to a zero-wait slave, the address of word k+1 is on the bus in the same cycle that word k is in its data phase.
- R2: A run of N words to a zero-wait slave occupies exactly N+1 bus cycles. After the completion pulse, the cycle counter reads N+1 and the beat counter reads N.
- R3: The transfer-type output is 2'b10 (first transfer) on the first address phase of a run and 2'b11 (sequential) on every later address phase of the run. It is 2'b00 (idle) at all other times. Each sequential address is the previous address plus 4.
- R4: Words are delivered in order. Word i carries the read data the slave returned for address start + 4*i, and exactly N words are delivered.
- R5: While the slave holds ready low, the address and transfer type stay unchanged into the next cycle.
- R6: A one-word run takes two bus cycles, and its cycle counter reads 2.
- R7: With W wait states on every word, a run of N words takes 1 + N*(1+W) cycles, as reported by the cycle counter.
- R8: The data-valid output pulses one cycle after each edge where a data phase was active and ready was high. The data output holds the read data sampled at that edge.
- R9: A start pulse is ignored while a run is in progress, and so is a start with a word count of zero. The bus stays idle and no completion pulse follows.
- R10: The completion pulse lasts one cycle and coincides with the data-valid pulse of the last word.
- R11: The write-enable output is always 0 and the size output is always 3'b010 (word).
- R12: After reset the bus is idle and data-valid and completion are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse that requests a run |
| cmd_addr | input | AW | Byte address of the first word |
| cmd_beats | input | CW | Number of words in the run |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type: 00 idle, 10 first, 11 sequential |
| hwrite | output | 1 | Write enable, always 0 |
| hsize | output | 3 | Transfer size, always word |
| hrdata | input | DW | Read data from the slave |
| hready | input | 1 | Slave ready; low stretches the data phase |
| rd_valid | output | 1 | Strobe for an accepted word |
| rd_data | output | DW | Accepted word |
| run_done | output | 1 | One-cycle pulse with the final word |
| cyc_count | output | KW | Bus cycles used by the latest run |
| beat_count | output | CW | Words accepted in the latest run |

## Verification
The hardest situation to reach is a stall that lands while an address phase and a data phase are both outstanding, with the next address already on the bus. A freeze bug there either skips an address or accepts a word twice. The bench uses a responsive slave model that inserts a programmable number of wait states at the start of every data phase. Runs of several lengths with one and two waits per word keep that overlapped-and-stalled state occurring on every word. Each run's data is checked against an address-derived pattern, and the cycle count is checked against the closed-form totals.

// File: rtl/strm_rd_pkg.sv
package strm_rd_pkg;

  // Bus transfer type encoding
  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  // Transfer size code for a 32-bit word
  localparam logic [2:0] HSZ_WORD = 3'b010;

endpackage

// File: rtl/strm_addr_gen.sv
// Address-phase sequencer: holds the transfer currently in its address
// phase and steps to the next one whenever the slave accepts.
module strm_addr_gen #(
  parameter int AW   = 32,
  parameter int CW   = 8,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_beats,
  input  logic          adv,
  output logic          a_valid,
  output logic          a_first,
  output logic          a_last,
  output logic [AW-1:0] a_addr
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic          vld_q,   vld_n;
  logic          first_q, first_n;
  logic [AW-1:0] addr_q,  addr_n;
  logic [CW-1:0] left_q,  left_n;
  logic          upd;

  assign upd = load | (adv & vld_q);

  always_comb begin
    vld_n   = vld_q;
    first_n = first_q;
    addr_n  = addr_q;
    left_n  = left_q;
    if (load) begin
      vld_n   = 1'b1;
      first_n = 1'b1;
      addr_n  = load_addr;
      left_n  = load_beats;
    end else if (adv && vld_q) begin
      first_n = 1'b0;
      if (left_q > ONE_C) begin
        addr_n = addr_q + STEP_V;
        left_n = left_q - ONE_C;
      end else begin
        vld_n  = 1'b0;
        left_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
    end else if (upd) begin
      vld_q   <= vld_n;
      first_q <= first_n;
      addr_q  <= addr_n;
      left_q  <= left_n;
    end
  end

  assign a_valid = vld_q;
  assign a_first = first_q;
  assign a_addr  = addr_q;
  assign a_last  = vld_q & (left_q == ONE_C);

endmodule

// File: rtl/strm_data_track.sv
// Data-phase tracker: follows the transfer in its data phase, captures
// read data on acceptance and raises completion with the final word.
module strm_data_track #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          a_valid,
  input  logic          a_last,
  input  logic [DW-1:0] hrdata,
  output logic          d_valid,
  output logic          beat_acc,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          run_done
);

  logic          dv_q, dv_n;
  logic          dl_q, dl_n;
  logic          rv_q, rv_n;
  logic          dn_q, dn_n;
  logic [DW-1:0] rdat_q;
  logic          accept;

  assign accept = dv_q & hready;

  always_comb begin
    dv_n = dv_q;
    dl_n = dl_q;
    if (hready) begin
      dv_n = a_valid;
      dl_n = a_last;
    end
    rv_n = accept;
    dn_n = accept & dl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q <= 1'b0;
      dl_q <= 1'b0;
      rv_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      dv_q <= dv_n;
      dl_q <= dl_n;
      rv_q <= rv_n;
      dn_q <= dn_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (accept) begin
      rdat_q <= hrdata;
    end
  end

  assign d_valid  = dv_q;
  assign beat_acc = accept;
  assign rd_valid = rv_q;
  assign rd_data  = rdat_q;
  assign run_done = dn_q;

endmodule

// File: rtl/strm_perf_cnt.sv
// Run counters: bus cycles occupied and words accepted since the last start.
module strm_perf_cnt #(
  parameter int KW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          busy,
  input  logic          beat_acc,
  output logic [KW-1:0] cyc_count,
  output logic [CW-1:0] beat_count
);

  logic [KW-1:0] cyc_q,  cyc_n;
  logic [CW-1:0] beat_q, beat_n;
  logic          en;

  assign en = clear | busy;

  always_comb begin
    if (clear) begin
      cyc_n  = '0;
      beat_n = '0;
    end else begin
      cyc_n  = cyc_q + KW'(1);
      beat_n = beat_q + CW'(beat_acc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      beat_q <= '0;
    end else if (en) begin
      cyc_q  <= cyc_n;
      beat_q <= beat_n;
    end
  end

  assign cyc_count  = cyc_q;
  assign beat_count = beat_q;

endmodule

// File: rtl/ahbl_stream_reader.sv
module ahbl_stream_reader
  import strm_rd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_beats,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          run_done,
  output logic [KW-1:0] cyc_count,
  output logic [CW-1:0] beat_count
);

  localparam int BYTES = DW / 8;

  logic a_valid, a_first, a_last;
  logic d_valid, beat_acc;
  logic busy, go;

  assign busy = a_valid | d_valid;
  assign go   = cmd_start & ~busy & (cmd_beats != '0);

  strm_addr_gen #(.AW(AW), .CW(CW), .STEP(BYTES)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (go),
    .load_addr  (cmd_addr),
    .load_beats (cmd_beats),
    .adv        (hready),
    .a_valid    (a_valid),
    .a_first    (a_first),
    .a_last     (a_last),
    .a_addr     (haddr)
  );

  strm_data_track #(.DW(DW)) u_dtrk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hready   (hready),
    .a_valid  (a_valid),
    .a_last   (a_last),
    .hrdata   (hrdata),
    .d_valid  (d_valid),
    .beat_acc (beat_acc),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .run_done (run_done)
  );

  strm_perf_cnt #(.KW(KW), .CW(CW)) u_perf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (go),
    .busy       (busy),
    .beat_acc   (beat_acc),
    .cyc_count  (cyc_count),
    .beat_count (beat_count)
  );

  assign htrans = a_valid ? (a_first ? HT_NONSEQ : HT_SEQ) : HT_IDLE;
  assign hwrite = 1'b0;
  assign hsize  = HSZ_WORD;

endmodule

// File: rtl/strm_rd_chk.sv
module strm_rd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic          hwrite,
  input logic [2:0]    hsize,
  input logic          hready,
  input logic          rd_valid,
  input logic          run_done
);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00 && !hready) |=> ($stable(haddr) && $stable(htrans)));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11 && $past(htrans != 2'b00 && hready))
      |-> (haddr == $past(haddr) + AW'(4)));

  // R3
  seq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> ($past(htrans) != 2'b00));

  // R11
  ctrl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hwrite == 1'b0) && (hsize == 3'b010));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> !run_done);

  // R10
  done_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> rd_valid);

  // R8
  valid_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(hready));

endmodule

bind ahbl_stream_reader strm_rd_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .haddr    (haddr),
  .htrans   (htrans),
  .hwrite   (hwrite),
  .hsize    (hsize),
  .hready   (hready),
  .rd_valid (rd_valid),
  .run_done (run_done)
);

// File: tb/ahbl_stream_reader_test.sv
module ahbl_stream_reader_test;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int KW = 16;

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  n;
    logic [3:0]  w;
    logic [15:0] cyc;
  } vec_t;

  // start, words, waits per word, expected cycles
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 8'd3,  4'd0, 16'd4},   // R2
    '{32'h0000_2040, 8'd1,  4'd0, 16'd2},   // R6
    '{32'h0000_3000, 8'd5,  4'd1, 16'd11},  // R7
    '{32'h0000_4100, 8'd8,  4'd0, 16'd9},   // R2
    '{32'h0000_5008, 8'd2,  4'd2, 16'd7},   // R7
    '{32'h0000_6000, 8'd16, 4'd0, 16'd17},  // R2
    '{32'h0000_7ffc, 8'd1,  4'd1, 16'd3}    // R7 single word
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_start;
  logic [AW-1:0] cmd_addr;
  logic [CW-1:0] cmd_beats;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic          hwrite;
  logic [2:0]    hsize;
  logic [DW-1:0] hrdata;
  logic          hready;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          run_done;
  logic [KW-1:0] cyc_count;
  logic [CW-1:0] beat_count;

  int tests_run = 0;
  int tests_failed = 0;

  always #4 clk = ~clk;

  ahbl_stream_reader #(.AW(AW), .DW(DW), .CW(CW), .KW(KW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_beats(cmd_beats), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hrdata(hrdata), .hready(hready), .rd_valid(rd_valid),
    .rd_data(rd_data), .run_done(run_done), .cyc_count(cyc_count),
    .beat_count(beat_count)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  // Slave model: waits wait_n cycles at the start of every data phase
  logic          sl_dph;
  logic [AW-1:0] sl_addr;
  logic [3:0]    sl_wc;
  logic [3:0]    wait_n;

  assign hready = !(sl_dph && (sl_wc < wait_n));
  assign hrdata = pat(sl_addr);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_dph  <= 1'b0;
      sl_addr <= '0;
      sl_wc   <= '0;
    end else if (hready) begin
      sl_dph  <= htrans[1];
      sl_addr <= haddr;
      sl_wc   <= '0;
    end else begin
      sl_wc <= sl_wc + 4'd1;
    end
  end

  // Monitor, sampled away from the active edge
  logic          mon_clr;
  logic [AW-1:0] base_addr;
  int got, data_err, done_cnt, done_err, ovl_cnt, ht_err, act_seen, ctl_err;
  logic [1:0] prev_ht;

  always @(negedge clk) begin
    if (mon_clr || !rst_n) begin
      got = 0; data_err = 0; done_cnt = 0; done_err = 0;
      ovl_cnt = 0; ht_err = 0; act_seen = 0; ctl_err = 0;
      prev_ht = 2'b00;
    end else begin
      if (rd_valid) begin
        if (rd_data !== pat(base_addr + AW'(4 * got))) data_err++;
        got++;
      end
      if (run_done) begin
        done_cnt++;
        if (!rd_valid) done_err++;
      end
      if (htrans == 2'b11 && sl_dph) ovl_cnt++;
      if (htrans != 2'b00 && prev_ht == 2'b00 && htrans != 2'b10) ht_err++;
      if (htrans == 2'b01) ht_err++;
      if (htrans != 2'b00) act_seen++;
      if (hwrite !== 1'b0 || hsize !== 3'b010) ctl_err++;
      prev_ht = htrans;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic pulse_start(input logic [AW-1:0] a, input logic [CW-1:0] n);
    cmd_addr  = a;
    cmd_beats = n;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int t = 0;
    while (!run_done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    ok = run_done;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog R2 act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    bit ok;
    rst_n = 1'b0; cmd_start = 1'b0; cmd_addr = '0; cmd_beats = '0;
    wait_n = 4'd0; mon_clr = 1'b1; base_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;

    // R12 reset state
    chk(htrans == 2'b00, "R12 htrans idle", int'(htrans), 0);
    chk(rd_valid == 1'b0, "R12 rd_valid low", int'(rd_valid), 0);
    chk(run_done == 1'b0, "R12 run_done low", int'(run_done), 0);
    chk(hwrite == 1'b0 && hsize == 3'b010, "R11 control", int'(hsize), 2);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      wait_n    = VECS[i].w;
      base_addr = VECS[i].addr;
      clear_mon();
      pulse_start(VECS[i].addr, CW'(VECS[i].n));
      wait_done(ok);
      chk(ok, "R10 completion seen", int'(ok), 1);
      chk(got == int'(VECS[i].n), "R4 word count", got, int'(VECS[i].n));
      chk(data_err == 0, "R4 R8 data order", data_err, 0);
      chk(int'(cyc_count) == int'(VECS[i].cyc), "R2 R6 R7 cycle count",
          int'(cyc_count), int'(VECS[i].cyc));
      chk(int'(beat_count) == int'(VECS[i].n), "R2 beat count",
          int'(beat_count), int'(VECS[i].n));
      chk(done_cnt == 1 && done_err == 0, "R10 single pulse with data", done_cnt, 1);
      chk(ht_err == 0, "R3 transfer type", ht_err, 0);
      chk(ctl_err == 0, "R11 control", ctl_err, 0);
      if (VECS[i].w == 4'd0)
        chk(ovl_cnt == int'(VECS[i].n) - 1, "R1 overlap", ovl_cnt, int'(VECS[i].n) - 1);
      else
        chk(sl_dph == 1'b0 && htrans == 2'b00, "R5 settled idle", int'(htrans), 0);
    end

    // R9 start during a run is ignored
    wait_n    = 4'd1;
    base_addr = 32'h0000_8000;
    clear_mon();
    pulse_start(32'h0000_8000, 8'd4);
    @(negedge clk);
    pulse_start(32'h0000_9000, 8'd2);
    wait_done(ok);
    repeat (4) @(negedge clk);
    chk(got == 4, "R9 busy start words", got, 4);
    chk(data_err == 0, "R9 busy start data", data_err, 0);
    chk(done_cnt == 1, "R9 busy start no second run", done_cnt, 1);
    chk(int'(cyc_count) == 9, "R9 R7 cycle count", int'(cyc_count), 9);

    // R9 zero-length start is ignored
    wait_n = 4'd0;
    clear_mon();
    pulse_start(32'h0000_a000, 8'd0);
    repeat (5) @(negedge clk);
    chk(act_seen == 0, "R9 zero count bus idle", act_seen, 0);
    chk(done_cnt == 0 && got == 0, "R9 zero count no completion", done_cnt, 0);
    chk(int'(cyc_count) == 9, "R9 counters untouched", int'(cyc_count), 9);

    // R12 reset in the middle of a run
    clear_mon();
    pulse_start(32'h0000_b000, 8'd6);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b00 && rd_valid == 1'b0 && run_done == 1'b0,
        "R12 reset mid-run", int'(htrans), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(htrans == 2'b00, "R12 idle after reset", int'(htrans), 0);

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule